// File: doc/BRIEF.md
# Cross-Core Prefetch Pollution Tracker

This block sits beside one core's prefetcher, called here the home core, and measures how much harm that prefetcher does to the other cores sharing the last-level cache. When a prefetch fill from the home core pushes out a demand line that belongs to some other core, the tracker marks a slot in a table of 1024 entries. The slot is picked by folding the evicted line address into ten bits, and the tracker stores the id of the core that lost the line. If that core later misses on an address that lands in a marked slot with its own id, the tracker counts one pollution event against the home core.

The count saturates. A throttling controller reads it at each sampling interval and clears it with a one-cycle interval-end pulse. A separate flush input wipes every mark in the table. The block takes two event streams, cache evictions and demand misses, and has no handshake. Each stream can present one event per cycle.

The count is kept by a two-state machine. In `CNT_RUN` the counter advances by one on each pollution hit. The transition `RUN_TO_FULL` is taken when a hit reaches the all-ones value, and the machine then sits in `CNT_FULL`, holding that value. The transition `ANY_TO_RUN` is taken on an interval-end pulse, from either state.

Top module: `xcore_pollution_tracker`

## Requirements
- R1: After reset the count is 0 and no table entry is marked, so a demand miss from any core adds nothing.
- R2: The table index is the XOR of line address bits [19:10] and bits [9:0]. Two addresses with the same folded value share one entry, so an eviction of one address followed by a miss on the other counts.
- R3: An entry is marked only when an eviction is valid, is flagged as caused by a home-core prefetch fill, is flagged as evicting a demand line, and has an owner id different from SELF_ID (default 1). If any of these conditions fails, a later miss on that entry adds nothing.
- R4: A valid miss whose entry is marked and holds an owner id equal to the missing core id adds exactly one to the count. The new value is visible after the clock edge at which the miss is presented. A miss from any other core id adds nothing and leaves the mark in place.
- R5: A miss that counts also clears the mark, so an immediate repeat of the same miss adds nothing.
- R6: When an eviction and a miss arrive in the same cycle and map to the same index, the miss is checked against the old contents first. The eviction is written afterwards, so the entry ends up marked with the new owner.
- R7: An eviction that maps to an entry which is already marked replaces the stored owner id. After that, only the new owner's misses count.
- R8: The count is 16 bits wide and holds at 65535 instead of wrapping.
- R9: An interval-end pulse clears the count to 0. If a counting miss arrives in the same cycle, the count becomes 1. The pulse does not change the table.
- R10: A flush clears every mark, and an eviction in the same cycle is dropped. A miss in the same cycle is still checked against the pre-flush contents. The flush leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Eviction event present |
| ev_line | input | 20 | Evicted line address |
| ev_owner | input | 2 | Core that owned the evicted line |
| ev_self_pf | input | 1 | Eviction caused by a home-core prefetch fill |
| ev_victim_demand | input | 1 | Evicted line was brought in by a demand access |
| ms_valid | input | 1 | Demand miss event present |
| ms_line | input | 20 | Missing line address |
| ms_core | input | 2 | Core that missed |
| interval_end | input | 1 | Clear the pollution count |
| flush | input | 1 | Clear all table marks |
| pol_count | output | 16 | Saturating pollution count |

## Verification
The internal state shows up only as the count, and only when a miss probes it. A mark that was wrongly set or wrongly cleared, or an owner id that is stale, shows up as a count off by one after the first miss that lands on that index. A fault in the counter state machine, either a wrap past the all-ones value or a missed clear, is visible on the very next edge. For these reasons, every probing miss is followed by a comparison against a model that is updated arithmetically from the stated rules, including during a long randomised run over a small set of addresses chosen to collide often.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_FULL = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/pf_line_fold.sv
module pf_line_fold #(
    parameter int LINE_W = 20,
    parameter int IDX_W  = 10
) (
    input  logic [LINE_W-1:0] line,
    output logic [IDX_W-1:0]  idx
);
    // Bit b of the line folds onto index bit (b mod IDX_W).
    always_comb begin
        idx = '0;
        for (int b = 0; b < LINE_W; b++) begin
            idx[b % IDX_W] = idx[b % IDX_W] ^ line[b];
        end
    end
endmodule

// File: rtl/pf_mark_table.sv
module pf_mark_table #(
    parameter int IDX_W  = 10,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_mark,
    output logic [CORE_W-1:0] rd_owner,
    input  logic              clr_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CORE_W-1:0] wr_owner,
    input  logic              flush
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] mark_q;
    logic [CORE_W-1:0]  owner_q [ENTRIES];

    assign rd_mark  = mark_q[rd_idx];
    assign rd_owner = owner_q[rd_idx];

    // The clear from a lookup comes before the write, so a write wins at the same index.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mark_q <= '0;
        end else begin
            if (clr_en) mark_q[rd_idx] <= 1'b0;
            if (wr_en)  mark_q[wr_idx] <= 1'b1;
        end
    end

    // Owner ids are only read behind a set mark, so they carry no reset.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) owner_q[wr_idx] <= wr_owner;
    end

    assert_write_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (mark_q[$past(wr_idx)] && owner_q[$past(wr_idx)] == $past(wr_owner)));

    assert_hit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_idx == rd_idx)) |=> !mark_q[$past(rd_idx)]);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mark_q == '0));
endmodule

// File: rtl/pf_sat_count.sv
module pf_sat_count
    import pf_filter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and next value.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = CNT_RUN;
            cnt_d   = inc ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
        end else begin
            unique case (state_q)
                CNT_RUN: begin
                    if (inc) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == CNT_LAST) state_d = CNT_FULL;
                    end
                end
                CNT_FULL: begin
                    cnt_d = CNT_MAX;
                end
                default: begin
                    state_d = CNT_RUN;
                end
            endcase
        end
    end

    // Output.
    always_comb begin
        count = cnt_q;
    end

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_FULL && !clr) |=> (count == CNT_MAX));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == {{(CNT_W-1){1'b0}}, $past(inc)}));
endmodule

// File: rtl/xcore_pollution_tracker.sv
module xcore_pollution_tracker #(
    parameter int LINE_W  = 20,
    parameter int IDX_W   = 10,
    parameter int CORE_W  = 2,
    parameter int CNT_W   = 16,
    parameter int SELF_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_line,
    input  logic [CORE_W-1:0] ev_owner,
    input  logic              ev_self_pf,
    input  logic              ev_victim_demand,
    input  logic              ms_valid,
    input  logic [LINE_W-1:0] ms_line,
    input  logic [CORE_W-1:0] ms_core,
    input  logic              interval_end,
    input  logic              flush,
    output logic [CNT_W-1:0]  pol_count
);
    localparam logic [CORE_W-1:0] HOME = CORE_W'(SELF_ID);

    logic [IDX_W-1:0]  ev_idx, ms_idx;
    logic              slot_mark;
    logic [CORE_W-1:0] slot_owner;
    logic              ev_take, ms_hit;

    pf_line_fold #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_fold_ev (.line(ev_line), .idx(ev_idx));
    pf_line_fold #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_fold_ms (.line(ms_line), .idx(ms_idx));

    assign ev_take = ev_valid && ev_self_pf && ev_victim_demand && (ev_owner != HOME);
    assign ms_hit  = ms_valid && slot_mark && (slot_owner == ms_core);

    pf_mark_table #(.IDX_W(IDX_W), .CORE_W(CORE_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ms_idx),
        .rd_mark  (slot_mark),
        .rd_owner (slot_owner),
        .clr_en   (ms_hit),
        .wr_en    (ev_take),
        .wr_idx   (ev_idx),
        .wr_owner (ev_owner),
        .flush    (flush)
    );

    pf_sat_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ms_hit),
        .clr   (interval_end),
        .count (pol_count)
    );

    assert_no_self_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_hit |-> (ms_core != HOME));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_valid && !interval_end) |=> $stable(pol_count));
endmodule

// File: tb/xcore_pollution_tracker_test.sv
module xcore_pollution_tracker_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ev_valid = 0, ev_self_pf = 0, ev_victim_demand = 0;
    logic [19:0] ev_line = 0, ms_line = 0;
    logic [1:0]  ev_owner = 0, ms_core = 0;
    logic        ms_valid = 0, interval_end = 0, flush = 0;
    logic [15:0] pol_count;

    int checks = 0, fails = 0;
    bit m_mark [1024];
    int m_own [1024];
    int m_cnt = 0;

    always #5 clk = ~clk;

    xcore_pollution_tracker uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_line(ev_line),
        .ev_owner(ev_owner), .ev_self_pf(ev_self_pf), .ev_victim_demand(ev_victim_demand),
        .ms_valid(ms_valid), .ms_line(ms_line), .ms_core(ms_core),
        .interval_end(interval_end), .flush(flush), .pol_count(pol_count));

    function automatic int fold(input logic [19:0] a);
        return int'(a[9:0] ^ a[19:10]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: pol_count=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; the model follows the stated rules.
    task automatic cyc(input bit ev, input logic [19:0] ea, input int eo, input bit pf,
                       input bit dm, input bit ms, input logic [19:0] ma, input int mc,
                       input bit ie, input bit fl);
        int he, hm;
        bit hit, take;
        ev_valid = ev; ev_line = ea; ev_owner = 2'(eo); ev_self_pf = pf;
        ev_victim_demand = dm; ms_valid = ms; ms_line = ma; ms_core = 2'(mc);
        interval_end = ie; flush = fl;
        he = fold(ea); hm = fold(ma);
        hit  = ms && m_mark[hm] && (m_own[hm] == mc);
        take = ev && pf && dm && (eo != 1);
        @(posedge clk);
        if (ie) m_cnt = hit ? 1 : 0;
        else if (hit && m_cnt < 65535) m_cnt++;
        if (fl) begin
            foreach (m_mark[k]) m_mark[k] = 0;
        end else begin
            if (hit) m_mark[hm] = 0;
            if (take) begin m_mark[he] = 1; m_own[he] = eo; end
        end
        #1;
        ev_valid = 0; ms_valid = 0; interval_end = 0; flush = 0;
    endtask

    task automatic evict(input logic [19:0] a, input int o);
        cyc(1, a, o, 1, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic miss(input logic [19:0] a, input int c);
        cyc(0, 0, 0, 0, 0, 1, a, c, 0, 0);
    endtask

    bit done = 0;
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: pol_count=%0d expected=finish", pol_count);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [19:0] A, B, C;
        foreach (m_mark[k]) begin m_mark[k] = 0; m_own[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R1", pol_count, 0);
        miss(20'h12345, 2); miss(20'h00000, 0); miss(20'h12345, 3);
        check("R1", pol_count, 0);

        evict(20'h00345, 2); miss(20'h00345, 2);
        check("R4", pol_count, 1);
        miss(20'h00345, 2);
        check("R5", pol_count, 1);

        evict(20'h01111, 3); miss(20'h01111, 2);
        check("R4", pol_count, 1);
        miss(20'h01111, 3);
        check("R4", pol_count, 2);

        evict(20'h02222, 1); miss(20'h02222, 1);
        cyc(1, 20'h02223, 2, 0, 1, 0, 0, 0, 0, 0); miss(20'h02223, 2);
        cyc(1, 20'h02224, 2, 1, 0, 0, 0, 0, 0, 0); miss(20'h02224, 2);
        cyc(0, 20'h02225, 2, 1, 1, 0, 0, 0, 0, 0); miss(20'h02225, 2);
        check("R3", pol_count, 2);

        A = {10'h015, 10'h02A}; B = {10'h02A, 10'h015};
        evict(A, 2); miss(20'h00007, 2);
        check("R2", pol_count, 2);
        miss(B, 2);
        check("R2", pol_count, 3);

        evict(A, 2); evict(B, 3); miss(A, 2);
        check("R7", pol_count, 3);
        miss(A, 3);
        check("R7", pol_count, 4);

        C = 20'h0ABCD;
        evict(C, 2);
        cyc(1, C, 3, 1, 1, 1, C, 2, 0, 0);
        check("R6", pol_count, 5);
        miss(C, 3);
        check("R6", pol_count, 6);

        evict(20'h04000, 2);
        cyc(1, 20'h05000, 2, 1, 1, 1, 20'h04000, 2, 0, 1);
        check("R10", pol_count, 7);
        miss(20'h05000, 2);
        check("R10", pol_count, 7);

        evict(20'h06000, 3);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        check("R9", pol_count, 0);
        cyc(0, 0, 0, 0, 0, 1, 20'h06000, 3, 1, 0);
        check("R9", pol_count, 1);

        // Randomised sweep over 32 addresses that collide often.
        for (int n = 0; n < 3000; n++) begin
            logic [19:0] ea, ma;
            ea = {15'(($urandom % 4) * 3), 5'($urandom % 8)};
            ma = {15'(($urandom % 4) * 3), 5'($urandom % 8)};
            cyc($urandom % 2, ea, $urandom % 4, ($urandom % 4) != 0, ($urandom % 4) != 0,
                $urandom % 2, ma, $urandom % 4, ($urandom % 97) == 0, ($urandom % 211) == 0);
            check("R4", pol_count, m_cnt);
        end

        // Saturation: evict and miss the same line every cycle.
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        evict(C, 2);
        for (int n = 0; n < 65540; n++) cyc(1, C, 2, 1, 1, 1, C, 2, 0, 0);
        check("R8", pol_count, 65535);
        check("R8", m_cnt, 65535);
        miss(C, 2);
        check("R8", pol_count, 65535);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule